// File: doc/BRIEF.md
# Tester Pattern Symbol Response Checker

This block sits behind the per-pin vector memory of a digital tester. Each tester cycle it receives one 4-bit symbol for every pin. It turns each symbol into a drive enable, a force value and an expectation for the pin. The expectation can be none, high, low or tri-state. The response of the device pin arrives as two comparator bits: one is set above the high threshold and the other is set below the low threshold.

The comparator bits are judged only when a strobe pulse arrives. Every strobe yields a per-pin fail vector with a one-cycle valid pulse. A strobe also advances a cycle index that restarts at reset or on a clear. The first failure sets a sticky flag, and the block latches both the cycle index and the lowest failing pin of that first failing strobe. These values hold until the next clear.

Top module: `pat_resp_checker`

## Requirements
- R1: Code 0 drives logic 0 and code 1 drives logic 1, each with drive enable set and expectation none (expect field 00).
- R2: Code 2 (expect high, field 01) and code 3 (expect low, field 10) leave the driver off.
- R3: Code 4 is don't care. The driver is off, the expectation is none, and the pin never fails whatever the comparator bits are.
- R4: Code 5 leaves the driver off and expects tri-state (field 11). It passes only when both comparator bits are 0.
- R5: Codes 6 to 9 drive and compare in the same cycle. Code 6 forces 0 and expects low. Code 7 forces 0 and expects high. Code 8 forces 1 and expects high. Code 9 forces 1 and expects low.
- R6: An expect-high pin passes exactly when its high comparator bit is 1. An expect-low pin passes exactly when its low comparator bit is 1. The other comparator bit does not matter.
- R7: Comparison happens only on a strobe. The per-pin fail vector and a valid pulse appear in the cycle after the strobe. Without a strobe, the fail vector holds its value and valid is 0.
- R8: Codes 10 to 15 are illegal. They raise the pin's illegal flag and are otherwise treated as don't care: the driver is off and the expectation is none.
- R9: The sticky fail flag sets on the first strobe with any failing pin and stays set until clear.
- R10: The first failing strobe latches its cycle index and its lowest failing pin index once. Later failures leave both values unchanged until clear.
- R11: The cycle index of a strobe is the number of strobes since reset or the last clear, so the first strobe has index 0.
- R12: Clear wins over a strobe in the same cycle. It zeroes the sticky flag, the fail vector, valid, the latched indices and the cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_i | input | NPINS*4 | Symbol code per pin, pin p at bits [4p+3:4p] |
| strobe_i | input | 1 | Strobe: judge comparator bits this cycle |
| cmp_hi_i | input | NPINS | Above-high-threshold comparator bit per pin |
| cmp_lo_i | input | NPINS | Below-low-threshold comparator bit per pin |
| clr_i | input | 1 | Clears sticky state and cycle count |
| drv_en_o | output | NPINS | Driver enable per pin |
| force_o | output | NPINS | Forced logic value per pin (0 when not driving) |
| expect_o | output | NPINS*2 | Expectation per pin: 00 none, 01 high, 10 low, 11 tri-state |
| illegal_o | output | NPINS | Illegal symbol code per pin |
| pin_fail_o | output | NPINS | Per-pin fail vector of the last strobe |
| fail_vld_o | output | 1 | Fail vector updated by the previous cycle's strobe |
| sticky_fail_o | output | 1 | Any failure since reset or clear |
| first_cyc_o | output | CYC_W | Cycle index of the first failing strobe |
| first_pin_o | output | PIN_W | Lowest failing pin of the first failing strobe |

## Verification
The hardest case to reach is a first failing strobe that is later than index 0, hits several pins at once, and is then followed by more failures on lower-numbered pins. Only that sequence shows that the latched cycle index, the lowest-pin selection and the freeze all work. The bench clears, runs four passing strobes, fails pins 5 and 9 together, and then fails pin 2 alone. It also lands a clear and a failing strobe on the same edge, so that clear priority and the restart of the count can both be observed.

// File: rtl/pat_pkg.sv
package pat_pkg;
  localparam logic [3:0] SYM_F0  = 4'd0;
  localparam logic [3:0] SYM_F1  = 4'd1;
  localparam logic [3:0] SYM_EH  = 4'd2;
  localparam logic [3:0] SYM_EL  = 4'd3;
  localparam logic [3:0] SYM_DC  = 4'd4;
  localparam logic [3:0] SYM_TRI = 4'd5;
  localparam logic [3:0] SYM_F0L = 4'd6;
  localparam logic [3:0] SYM_F0H = 4'd7;
  localparam logic [3:0] SYM_F1H = 4'd8;
  localparam logic [3:0] SYM_F1L = 4'd9;

  typedef enum logic [1:0] {
    EXP_NONE = 2'b00,
    EXP_HI   = 2'b01,
    EXP_LO   = 2'b10,
    EXP_TRI  = 2'b11
  } exp_e;

  typedef struct packed {
    logic drv;
    logic frc;
    exp_e exp;
    logic ill;
  } pin_ctl_t;
endpackage

// File: rtl/sym_decode.sv
module sym_decode
  import pat_pkg::*;
(
  input  logic [3:0] sym,
  output pin_ctl_t   ctl
);
  always_comb begin
    ctl = '{drv: 1'b0, frc: 1'b0, exp: EXP_NONE, ill: 1'b0};
    case (sym)
      SYM_F0:  ctl.drv = 1'b1;
      SYM_F1:  begin ctl.drv = 1'b1; ctl.frc = 1'b1; end
      SYM_EH:  ctl.exp = EXP_HI;
      SYM_EL:  ctl.exp = EXP_LO;
      SYM_DC:  ;
      SYM_TRI: ctl.exp = EXP_TRI;
      SYM_F0L: begin ctl.drv = 1'b1; ctl.exp = EXP_LO; end
      SYM_F0H: begin ctl.drv = 1'b1; ctl.exp = EXP_HI; end
      SYM_F1H: begin ctl.drv = 1'b1; ctl.frc = 1'b1; ctl.exp = EXP_HI; end
      SYM_F1L: begin ctl.drv = 1'b1; ctl.frc = 1'b1; ctl.exp = EXP_LO; end
      default: ctl.ill = 1'b1;
    endcase
  end

  // R8: an illegal code must never drive or compare
  always_comb begin
    if (ctl.ill) begin
      a_r8_illegal_quiet: assert (!ctl.drv && !ctl.frc && ctl.exp == EXP_NONE);
    end
  end
endmodule

// File: rtl/pin_compare.sv
module pin_compare
  import pat_pkg::*;
(
  input  exp_e exp,
  input  logic hi,
  input  logic lo,
  output logic fail
);
  always_comb begin
    fail = 1'b0;
    case (exp)
      EXP_HI:  fail = !hi;
      EXP_LO:  fail = !lo;
      EXP_TRI: fail = hi || lo;
      default: fail = 1'b0;
    endcase
  end

  // R3: no expectation can never report a failure
  always_comb begin
    if (exp == EXP_NONE) begin
      a_r3_none_never_fails: assert (!fail);
    end
  end
endmodule

// File: rtl/fail_log.sv
module fail_log #(
  parameter int NPINS = 16,
  parameter int CYC_W = 16,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             clr,
  input  logic [NPINS-1:0] raw_fail,
  output logic [NPINS-1:0] pin_fail_q,
  output logic             vld_q,
  output logic             sticky_q,
  output logic [CYC_W-1:0] first_cyc_q,
  output logic [PIN_W-1:0] first_pin_q
);
  logic [CYC_W-1:0] cyc_q, cyc_d, first_cyc_d;
  logic [PIN_W-1:0] first_pin_d, low_pin;
  logic [NPINS-1:0] pin_fail_d;
  logic             vld_d, sticky_d, any_fail, pf_en;

  always_comb begin
    low_pin = '0;
    for (int p = NPINS - 1; p >= 0; p--) begin
      if (raw_fail[p]) low_pin = PIN_W'(p);
    end
  end

  assign any_fail = |raw_fail;

  always_comb begin
    cyc_d       = cyc_q;
    pin_fail_d  = pin_fail_q;
    vld_d       = 1'b0;
    sticky_d    = sticky_q;
    first_cyc_d = first_cyc_q;
    first_pin_d = first_pin_q;
    pf_en       = 1'b0;
    if (clr) begin
      cyc_d       = '0;
      pin_fail_d  = '0;
      sticky_d    = 1'b0;
      first_cyc_d = '0;
      first_pin_d = '0;
      pf_en       = 1'b1;
    end else if (strobe) begin
      cyc_d      = cyc_q + 1'b1;
      pin_fail_d = raw_fail;
      vld_d      = 1'b1;
      pf_en      = 1'b1;
      if (any_fail && !sticky_q) begin
        sticky_d    = 1'b1;
        first_cyc_d = cyc_q;
        first_pin_d = low_pin;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q       <= '0;
      pin_fail_q  <= '0;
      vld_q       <= 1'b0;
      sticky_q    <= 1'b0;
      first_cyc_q <= '0;
      first_pin_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (pf_en) begin
        cyc_q       <= cyc_d;
        pin_fail_q  <= pin_fail_d;
        sticky_q    <= sticky_d;
        first_cyc_q <= first_cyc_d;
        first_pin_q <= first_pin_d;
      end
    end
  end

  a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && !clr) |=> sticky_q);
  a_r10_first_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && !clr) |=> ($stable(first_cyc_q) && $stable(first_pin_q)));
  a_r7_vld_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !clr) |=> vld_q);
  a_r7_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !clr) |=> (!vld_q && $stable(pin_fail_q)));
  a_r12_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!sticky_q && !vld_q && pin_fail_q == '0));
  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !clr) |=> (cyc_q == CYC_W'($past(cyc_q) + 1'b1)));
endmodule

// File: rtl/pat_resp_checker.sv
module pat_resp_checker
  import pat_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int CYC_W = 16,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS*4-1:0] sym_i,
  input  logic               strobe_i,
  input  logic [NPINS-1:0]   cmp_hi_i,
  input  logic [NPINS-1:0]   cmp_lo_i,
  input  logic               clr_i,
  output logic [NPINS-1:0]   drv_en_o,
  output logic [NPINS-1:0]   force_o,
  output logic [NPINS*2-1:0] expect_o,
  output logic [NPINS-1:0]   illegal_o,
  output logic [NPINS-1:0]   pin_fail_o,
  output logic               fail_vld_o,
  output logic               sticky_fail_o,
  output logic [CYC_W-1:0]   first_cyc_o,
  output logic [PIN_W-1:0]   first_pin_o
);
  logic [NPINS-1:0] raw_fail;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_ctl_t ctl;
    sym_decode u_dec (
      .sym (sym_i[4*p +: 4]),
      .ctl (ctl)
    );
    pin_compare u_cmp (
      .exp  (ctl.exp),
      .hi   (cmp_hi_i[p]),
      .lo   (cmp_lo_i[p]),
      .fail (raw_fail[p])
    );
    assign drv_en_o[p]       = ctl.drv;
    assign force_o[p]        = ctl.frc;
    assign expect_o[2*p +: 2] = ctl.exp;
    assign illegal_o[p]      = ctl.ill;
  end

  fail_log #(.NPINS(NPINS), .CYC_W(CYC_W)) u_log (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe_i),
    .clr         (clr_i),
    .raw_fail    (raw_fail),
    .pin_fail_q  (pin_fail_o),
    .vld_q       (fail_vld_o),
    .sticky_q    (sticky_fail_o),
    .first_cyc_q (first_cyc_o),
    .first_pin_q (first_pin_o)
  );

  // R2: an expect-only symbol must never turn the driver on
  a_r2_compare_only_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_i[3:0] == SYM_EH || sym_i[3:0] == SYM_EL) |-> !drv_en_o[0]);
endmodule

// File: tb/pat_resp_checker_tb_top.sv
module pat_resp_checker_tb_top;
  localparam int NPINS = 16;
  localparam int CYC_W = 16;
  localparam int PIN_W = $clog2(NPINS);
  localparam int NROWS = 24;

  // row: sym[15:12] hi[11] lo[10] drv[9] frc[8] exp[7:6] fail[5] ill[4] rsv[3:0]
  localparam logic [15:0] TBL [NROWS] = '{
    {4'd0,  1'b0,1'b0, 1'b1,1'b0, 2'b00, 1'b0,1'b0, 4'h0}, // R1
    {4'd1,  1'b1,1'b1, 1'b1,1'b1, 2'b00, 1'b0,1'b0, 4'h0}, // R1
    {4'd2,  1'b1,1'b0, 1'b0,1'b0, 2'b01, 1'b0,1'b0, 4'h0}, // R2 R6
    {4'd2,  1'b0,1'b0, 1'b0,1'b0, 2'b01, 1'b1,1'b0, 4'h0}, // R2 R6 first fail
    {4'd3,  1'b0,1'b1, 1'b0,1'b0, 2'b10, 1'b0,1'b0, 4'h0}, // R2
    {4'd3,  1'b1,1'b0, 1'b0,1'b0, 2'b10, 1'b1,1'b0, 4'h0}, // R2
    {4'd4,  1'b1,1'b1, 1'b0,1'b0, 2'b00, 1'b0,1'b0, 4'h0}, // R3
    {4'd4,  1'b0,1'b0, 1'b0,1'b0, 2'b00, 1'b0,1'b0, 4'h0}, // R3
    {4'd5,  1'b0,1'b0, 1'b0,1'b0, 2'b11, 1'b0,1'b0, 4'h0}, // R4
    {4'd5,  1'b1,1'b0, 1'b0,1'b0, 2'b11, 1'b1,1'b0, 4'h0}, // R4
    {4'd5,  1'b0,1'b1, 1'b0,1'b0, 2'b11, 1'b1,1'b0, 4'h0}, // R4
    {4'd6,  1'b0,1'b1, 1'b1,1'b0, 2'b10, 1'b0,1'b0, 4'h0}, // R5
    {4'd6,  1'b1,1'b0, 1'b1,1'b0, 2'b10, 1'b1,1'b0, 4'h0}, // R5
    {4'd7,  1'b1,1'b0, 1'b1,1'b0, 2'b01, 1'b0,1'b0, 4'h0}, // R5
    {4'd7,  1'b0,1'b1, 1'b1,1'b0, 2'b01, 1'b1,1'b0, 4'h0}, // R5
    {4'd8,  1'b1,1'b0, 1'b1,1'b1, 2'b01, 1'b0,1'b0, 4'h0}, // R5
    {4'd8,  1'b0,1'b0, 1'b1,1'b1, 2'b01, 1'b1,1'b0, 4'h0}, // R5
    {4'd9,  1'b0,1'b1, 1'b1,1'b1, 2'b10, 1'b0,1'b0, 4'h0}, // R5
    {4'd9,  1'b1,1'b1, 1'b1,1'b1, 2'b10, 1'b0,1'b0, 4'h0}, // R5 R6
    {4'd8,  1'b1,1'b1, 1'b1,1'b1, 2'b01, 1'b0,1'b0, 4'h0}, // R6
    {4'd10, 1'b0,1'b0, 1'b0,1'b0, 2'b00, 1'b0,1'b1, 4'h0}, // R8
    {4'd12, 1'b1,1'b0, 1'b0,1'b0, 2'b00, 1'b0,1'b1, 4'h0}, // R8
    {4'd15, 1'b1,1'b1, 1'b0,1'b0, 2'b00, 1'b0,1'b1, 4'h0}, // R8
    {4'd4,  1'b0,1'b1, 1'b0,1'b0, 2'b00, 1'b0,1'b0, 4'h0}  // R3
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NPINS*4-1:0] sym_i;
  logic               strobe_i, clr_i;
  logic [NPINS-1:0]   cmp_hi_i, cmp_lo_i;
  logic [NPINS-1:0]   drv_en_o, force_o, illegal_o, pin_fail_o;
  logic [NPINS*2-1:0] expect_o;
  logic               fail_vld_o, sticky_fail_o;
  logic [CYC_W-1:0]   first_cyc_o;
  logic [PIN_W-1:0]   first_pin_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pat_resp_checker #(.NPINS(NPINS), .CYC_W(CYC_W)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobe_pulse(input bit with_clr);
    strobe_i = 1'b1;
    clr_i    = with_clr;
    @(posedge clk); #2;
    strobe_i = 1'b0;
    clr_i    = 1'b0;
  endtask

  task automatic set_pins(input logic [3:0] code, input logic hi, input logic lo);
    sym_i    = {NPINS{code}};
    cmp_hi_i = {NPINS{hi}};
    cmp_lo_i = {NPINS{lo}};
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; strobe_i = 1'b0; clr_i = 1'b0;
    set_pins(4'd4, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    // reset state (R12)
    chk(!sticky_fail_o && !fail_vld_o && pin_fail_o == '0 && first_cyc_o == '0,
        "R12 reset state", {sticky_fail_o, fail_vld_o}, 0);

    // table walk
    for (int r = 0; r < NROWS; r++) begin
      logic [15:0] row;
      row = TBL[r];
      set_pins(row[15:12], row[11], row[10]);
      #2;
      chk(drv_en_o == {NPINS{row[9]}}, "R1 R2 R5 drv_en", drv_en_o, {NPINS{row[9]}});
      chk(force_o == {NPINS{row[8]}}, "R1 R5 force", force_o, {NPINS{row[8]}});
      chk(expect_o == {NPINS{row[7:6]}}, "R2 R4 R5 expect", expect_o, {NPINS{row[7:6]}});
      chk(illegal_o == {NPINS{row[4]}}, "R8 illegal", illegal_o, {NPINS{row[4]}});
      strobe_pulse(1'b0);
      chk(fail_vld_o, "R7 valid", fail_vld_o, 1);
      chk(pin_fail_o == {NPINS{row[5]}}, "R3 R4 R6 pin fail", pin_fail_o, {NPINS{row[5]}});
    end
    chk(sticky_fail_o, "R9 sticky after table", sticky_fail_o, 1);
    chk(first_cyc_o == 3, "R10 R11 first cycle", first_cyc_o, 3);
    chk(first_pin_o == 0, "R10 first pin", first_pin_o, 0);

    // clear then multi-pin first failure at index 4
    clr_i = 1'b1; @(posedge clk); #2; clr_i = 1'b0;
    chk(!sticky_fail_o && first_cyc_o == 0 && pin_fail_o == '0, "R12 clear", sticky_fail_o, 0);
    set_pins(4'd4, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) strobe_pulse(1'b0);
    chk(!sticky_fail_o, "R3 passing strobes", sticky_fail_o, 0);
    sym_i[4*5 +: 4] = 4'd2;
    sym_i[4*9 +: 4] = 4'd2;
    strobe_pulse(1'b0);
    chk(pin_fail_o == 16'h0220, "R6 pins 5 and 9", pin_fail_o, 16'h0220);
    chk(first_cyc_o == 4, "R11 first cycle 4", first_cyc_o, 4);
    chk(first_pin_o == 5, "R10 lowest pin", first_pin_o, 5);

    // no strobe: comparator change has no effect (R7)
    cmp_hi_i = '1;
    repeat (2) @(posedge clk); #2;
    chk(pin_fail_o == 16'h0220 && !fail_vld_o, "R7 no strobe hold", pin_fail_o, 16'h0220);

    // later failure on a lower pin leaves latch alone
    set_pins(4'd4, 1'b0, 1'b0);
    sym_i[4*2 +: 4] = 4'd3;
    strobe_pulse(1'b0);
    chk(pin_fail_o == 16'h0004, "R6 pin 2 fail", pin_fail_o, 16'h0004);
    chk(first_pin_o == 5 && first_cyc_o == 4, "R10 latch frozen", first_pin_o, 5);
    chk(sticky_fail_o, "R9 still sticky", sticky_fail_o, 1);

    // clear and failing strobe together: clear wins
    strobe_pulse(1'b1);
    chk(!sticky_fail_o && !fail_vld_o && pin_fail_o == '0, "R12 clear beats strobe",
        {sticky_fail_o, fail_vld_o}, 0);
    set_pins(4'd4, 1'b1, 1'b1);
    strobe_pulse(1'b0);
    chk(fail_vld_o && pin_fail_o == '0 && !sticky_fail_o, "R3 pass after clear", pin_fail_o, 0);
    set_pins(4'd4, 1'b0, 1'b0);
    sym_i[4*2 +: 4] = 4'd5;
    cmp_lo_i[2] = 1'b1;
    strobe_pulse(1'b0);
    chk(first_cyc_o == 1 && first_pin_o == 2, "R11 count restarted", first_cyc_o, 1);
    chk(sticky_fail_o, "R4 R9 tri fail sticky", sticky_fail_o, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule